// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps time of day and calendar date for a chip that receives a 32.768 kHz tick as a single-cycle enable on its system clock. A fractional divider turns the ticks into hundredths of a second. The hundredths carry into seconds, minutes and 24-hour hours. Midnight then advances the day of week and the date. The date carries through month and year into a two-bit century field. Every field is stored in BCD. Month lengths follow the calendar, and each year divisible by four gets 29 days in February.

The running (internal) copy advances on its own. Software sees a separate user copy that is loaded from the running copy in a single cycle. A bus agent raises `freeze` while it reads clock registers. The user copy then holds still and gives a coherent multi-byte read, while the running copy keeps counting. A write port loads any clock register. Every write also returns the sub-second state to zero. A stop bit halts counting.

Top module: `rtc_calendar_core`

## Requirements
- R1: Register view by address: 0 hundredths, 1 seconds with the stop bit in bit 7, 2 minutes, 3 hours (00-23), 4 day of week in bits 2:0, 5 date, 6 century in bits 7:6 with month in bits 4:0, 7 year. Unused bits read 0. After reset the view is 00:00:00.00, day 1, date 01, month 01, year 00, century 0, stop 0.
- R2: Each tick adds HUND_RATE to a divider accumulator. When the sum reaches TICK_RATE or more, TICK_RATE is subtracted and the hundredths advance. Hundredths wrap from 99 to 00 and advance the seconds.
- R3: Seconds wrap 59 to 00 and advance minutes. Minutes wrap 59 to 00 and advance hours. Hours wrap 23 to 00 and start a new day.
- R4: The date wraps to 01 after the last day of the month and advances the month. April, June, September and November have 30 days. February has 29 days when the year is divisible by 4 (including 00) and 28 days otherwise. All other months have 31 days.
- R5: The day of week advances at each new day and wraps from 7 to 1.
- R6: The month wraps 12 to 01 and advances the year. The year wraps 99 to 00 and increments the century modulo 4.
- R7: Every write, to any address, clears the hundredths to 00 and empties the divider accumulator. A value written to address 0 is ignored.
- R8: While the stop bit is 1, ticks change nothing. After the bit is cleared, counting resumes.
- R9: With `freeze` low, the user copy is reloaded from the running copy on every clock. With `freeze` high, the whole user copy holds.
- R10: During `freeze` the running copy keeps counting. One clock after `freeze` falls, the user copy shows the fully advanced time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle pulse per oscillator period |
| freeze | input | 1 | Holds the user copy while a clock register read is in progress |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | 8 | Write data in the R1 layout |
| rd_addr | input | 3 | Register address of the user-copy read |
| rd_data | output | 8 | User-copy register value, combinational from rd_addr |

## Verification
The range assertions assume that every write carries legal BCD within the field's range. They also assume the date fits the month, the day of week is 1 to 7, and the hour is below 24. The design wraps illegal values but does not repair them. The bench keeps to these rules: its random times are built from binary values that are first checked against a month-length function, then converted to BCD. It only raises `freeze` as a steady level between whole tick bursts. HUND_RATE is assumed not to exceed TICK_RATE, so at most one hundredth step happens per tick.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef struct packed {
    logic       stop;
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic [2:0] dow;
    logic [5:0] date;
    logic [1:0] cent;
    logic [4:0] month;
    logic [7:0] year;
  } cal_t;

  localparam cal_t CAL_RESET = '{stop: 1'b0, sec: 7'h00, min: 7'h00, hour: 6'h00,
                                 dow: 3'd1, date: 6'h01, cent: 2'd0, month: 5'h01,
                                 year: 8'h00};

  // two-digit BCD increment without range wrap
  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_next = {v[7:4] + 4'd1, 4'd0};
    else                bcd_next = v + 8'd1;
  endfunction

  // divisible by 4, judged from the BCD digits
  function automatic logic year_is_leap(input logic [7:0] y);
    if (y[4]) year_is_leap = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      year_is_leap = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [5:0] month_last(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      month_last = year_is_leap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: month_last = 6'h30;
      default:                    month_last = 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_subsec_div.sv
module rtc_subsec_div #(
  parameter int TICK_RATE = 32768,
  parameter int HUND_RATE = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       stop,
  input  logic       clr,
  output logic [7:0] hund_q,
  output logic       sec_step
);
  import rtc_cal_pkg::*;

  localparam int ACC_W = $clog2(TICK_RATE + HUND_RATE) + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;
  logic             hund_step;
  logic             run;

  always_comb begin
    run       = tick_en && !stop;
    acc_sum   = acc_q + ACC_W'(HUND_RATE);
    hund_step = run && (acc_sum >= ACC_W'(TICK_RATE));
    sec_step  = hund_step && (hund_q == 8'h99);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      hund_q <= 8'h00;
    end else if (clr) begin
      acc_q  <= '0;
      hund_q <= 8'h00;
    end else if (run) begin
      acc_q <= hund_step ? acc_sum - ACC_W'(TICK_RATE) : acc_sum;
      if (hund_step) hund_q <= (hund_q == 8'h99) ? 8'h00 : bcd_next(hund_q);
    end
  end

  assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hund_q == 8'h00)) else $error("write did not clear hundredths");

  assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !clr) |=> $stable(hund_q)) else $error("hundredths moved while stopped");

  assert_hund_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hund_q[3:0] <= 4'd9) && (hund_q[7:4] <= 4'd9)) else $error("hundredths not BCD");

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_step,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output rtc_cal_pkg::cal_t cal_q
);
  import rtc_cal_pkg::*;

  logic sec_wrap, min_wrap, day_step, month_step, year_step, cent_step;

  always_comb begin
    sec_wrap   = sec_step && (cal_q.sec >= 7'h59);
    min_wrap   = sec_wrap && (cal_q.min >= 7'h59);
    day_step   = min_wrap && (cal_q.hour >= 6'h23);
    month_step = day_step && (cal_q.date >= month_last(cal_q.month, cal_q.year));
    year_step  = month_step && (cal_q.month >= 5'h12);
    cent_step  = year_step && (cal_q.year >= 8'h99);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q <= CAL_RESET;
    end else if (wr_en) begin
      case (wr_addr)
        3'd1: begin cal_q.stop <= wr_data[7]; cal_q.sec <= wr_data[6:0]; end
        3'd2: cal_q.min  <= wr_data[6:0];
        3'd3: cal_q.hour <= wr_data[5:0];
        3'd4: cal_q.dow  <= wr_data[2:0];
        3'd5: cal_q.date <= wr_data[5:0];
        3'd6: begin cal_q.cent <= wr_data[7:6]; cal_q.month <= wr_data[4:0]; end
        3'd7: cal_q.year <= wr_data;
        default: ;
      endcase
    end else if (sec_step) begin
      cal_q.sec <= sec_wrap ? 7'h00 : 7'(bcd_next({1'b0, cal_q.sec}));
      if (sec_wrap) cal_q.min  <= min_wrap ? 7'h00 : 7'(bcd_next({1'b0, cal_q.min}));
      if (min_wrap) cal_q.hour <= day_step ? 6'h00 : 6'(bcd_next({2'b0, cal_q.hour}));
      if (day_step) begin
        cal_q.dow  <= (cal_q.dow >= 3'd7) ? 3'd1 : cal_q.dow + 3'd1;
        cal_q.date <= month_step ? 6'h01 : 6'(bcd_next({2'b0, cal_q.date}));
      end
      if (month_step) cal_q.month <= year_step ? 5'h01 : 5'(bcd_next({3'b0, cal_q.month}));
      if (year_step)  cal_q.year  <= cent_step ? 8'h00 : bcd_next(cal_q.year);
      if (cent_step)  cal_q.cent  <= cal_q.cent + 2'd1;
    end
  end

  assert_sec_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_q.sec <= 7'h59) && (cal_q.min <= 7'h59) && (cal_q.hour <= 6'h23))
    else $error("time field out of range");

  assert_date_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (month_step && !wr_en) |=> (cal_q.date == 6'h01)) else $error("date did not wrap");

  assert_dow_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_q.dow != 3'd0)) else $error("day of week is zero");

  assert_century_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cent_step && !wr_en) |=> (cal_q.cent == $past(cal_q.cent) + 2'd1))
    else $error("century did not advance");

endmodule

// File: rtl/rtc_user_shadow.sv
module rtc_user_shadow (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  rtc_cal_pkg::cal_t cal_in,
  input  logic [7:0]        hund_in,
  input  logic [2:0]        rd_addr,
  output logic [7:0]        rd_data
);
  import rtc_cal_pkg::*;

  cal_t       user_cal;
  logic [7:0] user_hund;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_cal  <= CAL_RESET;
      user_hund <= 8'h00;
    end else if (!freeze) begin
      user_cal  <= cal_in;
      user_hund <= hund_in;
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = user_hund;
      3'd1:    rd_data = {user_cal.stop, user_cal.sec};
      3'd2:    rd_data = {1'b0, user_cal.min};
      3'd3:    rd_data = {2'b0, user_cal.hour};
      3'd4:    rd_data = {5'b0, user_cal.dow};
      3'd5:    rd_data = {2'b0, user_cal.date};
      3'd6:    rd_data = {user_cal.cent, 1'b0, user_cal.month};
      default: rd_data = user_cal.year;
    endcase
  end

  assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(user_cal) && $stable(user_hund))) else $error("user copy moved in freeze");

  assert_refresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |=> ((user_cal == $past(cal_in)) && (user_hund == $past(hund_in))))
    else $error("user copy not refreshed");

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
  parameter int TICK_RATE = 32768,
  parameter int HUND_RATE = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       freeze,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);
  import rtc_cal_pkg::*;

  cal_t       cal_run;
  logic [7:0] hund_run;
  logic       sec_step;

  rtc_subsec_div #(.TICK_RATE(TICK_RATE), .HUND_RATE(HUND_RATE)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .stop(cal_run.stop),
    .clr(wr_en), .hund_q(hund_run), .sec_step(sec_step)
  );

  rtc_time_chain u_chain (
    .clk(clk), .rst_n(rst_n), .sec_step(sec_step), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .cal_q(cal_run)
  );

  rtc_user_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .cal_in(cal_run),
    .hund_in(hund_run), .rd_addr(rd_addr), .rd_data(rd_data)
  );

endmodule

// File: tb/test_rtc_calendar_core.sv
`timescale 1ns/1ps
module test_rtc_calendar_core;
  localparam int TR = 250;
  localparam int HR = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0, freeze = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model in binary
  int m_acc, m_h, m_s, m_m, m_hr, m_dow, m_d, m_mo, m_y, m_c;
  bit m_stop;

  always #2 clk = ~clk;

  rtc_calendar_core #(.TICK_RATE(TR), .HUND_RATE(HR)) i_rtc_calendar_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int days_in(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_reg(input int a);
    case (a)
      0: return to_bcd(m_h);
      1: return {m_stop, 7'(to_bcd(m_s))};
      2: return to_bcd(m_m);
      3: return to_bcd(m_hr);
      4: return 8'(m_dow);
      5: return to_bcd(m_d);
      6: return {2'(m_c), 6'(to_bcd(m_mo))};
      default: return to_bcd(m_y);
    endcase
  endfunction

  task automatic model_tick();
    if (m_stop) return;
    m_acc += HR;
    if (m_acc < TR) return;
    m_acc -= TR;
    m_h++;
    if (m_h < 100) return;
    m_h = 0; m_s++;
    if (m_s < 60) return;
    m_s = 0; m_m++;
    if (m_m < 60) return;
    m_m = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
    m_d++;
    if (m_d <= days_in(m_mo, m_y)) return;
    m_d = 1; m_mo++;
    if (m_mo <= 12) return;
    m_mo = 1; m_y++;
    if (m_y < 100) return;
    m_y = 0; m_c = (m_c + 1) % 4;
  endtask

  task automatic check(input string tag, input int a, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr %0d actual %02h expected %02h", tag, a, got, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #0.5;
      check(tag, a, rd_data, exp_reg(a));
    end
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_acc = 0; m_h = 0;
    case (a)
      1: begin m_stop = d[7]; m_s = from_bcd({1'b0, d[6:0]}); end
      2: m_m = from_bcd(d);
      3: m_hr = from_bcd(d);
      4: m_dow = int'(d[2:0]);
      5: m_d = from_bcd(d);
      6: begin m_c = int'(d[7:6]); m_mo = from_bcd({3'b0, d[4:0]}); end
      7: m_y = from_bcd(d);
      default: ;
    endcase
  endtask

  task automatic set_time(input int c, input int y, input int mo, input int d, input int dw,
                          input int hr, input int mi, input int s);
    wr(7, to_bcd(y));
    wr(6, {2'(c), 6'(to_bcd(mo))});
    wr(5, to_bcd(d));
    wr(4, 8'(dw));
    wr(3, to_bcd(hr));
    wr(2, to_bcd(mi));
    wr(1, to_bcd(s));
    wr(0, 8'h47); // R7: ignored value, still clears
    settle();
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
      model_tick();
    end
    @(negedge clk);
    tick_en = 1'b0;
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] snap [8];
    void'($urandom(32'd4177));
    m_acc = 0; m_h = 0; m_s = 0; m_m = 0; m_hr = 0; m_dow = 1;
    m_d = 1; m_mo = 1; m_y = 0; m_c = 0; m_stop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    check_regs("R1 reset");

    // R2: divider fraction, hundredths carry into seconds
    run_ticks(257);
    check_regs("R2 divider");

    // R3 and R5: midnight, day of week 7 wraps to 1
    set_time(1, 45, 7, 14, 7, 23, 59, 59);
    run_ticks(255);
    check_regs("R3 R5 midnight");

    // R4: leap February (year 24), non-leap (23), year 00, 30-day month
    set_time(0, 24, 2, 28, 3, 23, 59, 59);
    run_ticks(252);
    check_regs("R4 leap 28");
    set_time(0, 24, 2, 29, 4, 23, 59, 59);
    run_ticks(252);
    check_regs("R4 leap 29");
    set_time(2, 23, 2, 28, 2, 23, 59, 59);
    run_ticks(252);
    check_regs("R4 nonleap");
    set_time(1, 0, 2, 28, 5, 23, 59, 59);
    run_ticks(252);
    check_regs("R4 year00");
    set_time(0, 10, 4, 30, 6, 23, 59, 59);
    run_ticks(252);
    check_regs("R4 thirty");

    // R6: year and century rollover, century wraps modulo 4
    set_time(3, 99, 12, 31, 7, 23, 59, 59);
    run_ticks(252);
    check_regs("R6 century");
    set_time(1, 58, 12, 31, 2, 23, 59, 59);
    run_ticks(252);
    check_regs("R6 year");

    // R7: write mid-count clears hundredths and the accumulator
    set_time(0, 30, 5, 10, 2, 8, 15, 20);
    run_ticks(4);
    wr(2, to_bcd(15));
    run_ticks(2);
    check_regs("R7 divider reset");
    run_ticks(40);
    wr(0, 8'h99);
    settle();
    check_regs("R7 addr0 ignored");

    // R8: stop bit
    wr(1, 8'hB0);
    run_ticks(300);
    check_regs("R8 stopped");
    wr(1, 8'h30);
    run_ticks(300);
    check_regs("R8 resumed");

    // R9 and R10: freeze holds the user copy, running copy continues
    set_time(0, 11, 3, 31, 1, 23, 59, 59);
    for (int a = 0; a < 8; a++) snap[a] = exp_reg(a);
    @(negedge clk);
    freeze = 1'b1;
    run_ticks(300);
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #0.5;
      check("R9 frozen", a, rd_data, snap[a]);
    end
    @(negedge clk);
    freeze = 1'b0;
    @(negedge clk);
    check_regs("R10 release");

    // random trials near and away from rollovers
    for (int t = 0; t < 30; t++) begin
      int y, mo, d, hr, mi, s;
      y  = $urandom_range(0, 99);
      mo = $urandom_range(1, 12);
      d  = ($urandom_range(0, 1) == 1) ? days_in(mo, y) : $urandom_range(1, days_in(mo, y));
      hr = ($urandom_range(0, 1) == 1) ? 23 : $urandom_range(0, 23);
      mi = ($urandom_range(0, 1) == 1) ? 59 : $urandom_range(0, 59);
      s  = ($urandom_range(0, 3) != 0) ? 59 : $urandom_range(0, 59);
      set_time($urandom_range(0, 3), y, mo, d, $urandom_range(1, 7), hr, mi, s);
      run_ticks($urandom_range(1, 600));
      check_regs("R2 R3 R4 R5 R6 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule